// File: doc/BRIEF.md
# Crossing Frame Link Framer

This block packs the energy codes of one card into a frame for a parallel point-to-point link. Once per crossing period it latches all channel codes and sends them as a fixed number of back-to-back transfer words. The transfers are paced by a transfer enable that runs at eight times the crossing rate. Every slot of the accelerator turn produces a frame, live or not. Each frame carries the slot number within the turn, a marker bit that flags its first transfer, and a modulo-256 checksum, so the receiver can find frame edges and detect corrupted frames.

A slot counter is zeroed by the turn-start marker and advances once per frame. A marker that arrives together with a transfer enable also restarts the transfer index. Every card on a shared marker therefore begins its frame on the same transfer. If the counter passes its last slot without a marker, an error flag is raised and stays high until the next marker. The finished word is driven on three identical copies, one for each downstream consumer.

Top module: `xfr_framer`

## Requirements
- R1: After reset all link copies, `frame_start` and `turn_err` are 0. Until the first marker has been taken with `xfer_en`, transfers leave the link words at all zeros.
- R2: When `turn_start` is high together with `xfer_en`, the next output is transfer 0 of a frame for slot 0. The input codes are latched at that moment, and this holds in any transfer position.
- R3: A frame has 8 transfers. Transfer k carries codes 4k..4k+3 in bits 31:0, with code 4k+j in bits 8j+7:8j. Code c is `codes_in[8c+7:8c]`.
- R4: Bit 32 of a word is 1 only on transfer 0, and `frame_start` equals that bit.
- R5: The slot number rises by one with each frame after transfer 7, from 0 to 158, and goes back to 0 after 158. A frame is sent for every slot.
- R6: The checksum is the sum modulo 256 of the 32 codes and the slot number. Bits 35:33 of transfers 0, 1 and 2 carry checksum bits [2:0], [5:3] and {0,[7:6]}. Transfers 3, 4 and 5 carry the slot number in the same layout. Transfers 6 and 7 carry 0 there.
- R7: Codes are latched only at frame start. Changes on `codes_in` during a frame do not alter the words of that frame.
- R8: The three 36-bit copies in `link_out` (copy n at bits 36n+35:36n) are always identical.
- R9: If a frame ends at slot 158 with no marker, `turn_err` goes to 1 and counting wraps to slot 0. It stays 1 until a marker is taken.
- R10: While `xfer_en` is low, the link words, `frame_start` and `turn_err` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transfer-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_en | input | 1 | One-cycle enable per link transfer (8 per crossing) |
| turn_start | input | 1 | First-crossing-of-turn marker, taken with `xfer_en` |
| codes_in | input | 256 | 32 eight-bit energy codes, code c at bits 8c+7:8c |
| link_out | output | 108 | Three identical 36-bit transfer words |
| frame_start | output | 1 | High while the words hold transfer 0 |
| turn_err | output | 1 | Marker missing after the last slot; cleared by a marker |

## Verification
Every transfer of more than two full turns is compared against words the bench builds from its own slot and transfer model. Between transfers the inputs carry deliberately different codes, so a framer that samples codes mid-frame is caught. The first turn is closed by a proper marker. The second turn ends with the marker missing, which separates a correct wrap-and-flag from a counter that stalls or runs to 159. A marker in mid-frame then shows that the transfer index, the slot number and the error flag all restart together. Idle gaps with the enable low, and enables given before any marker, separate a framer paced by the enable from one that free-runs on the clock.

// File: rtl/xfr_pkg.sv
package xfr_pkg;
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/xfr_slot_ctr.sv
module xfr_slot_ctr #(
  parameter int XFERS = 8,
  parameter int SLOTS = 159,
  localparam int IDX_W = $clog2(XFERS),
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_en,
  input  logic              turn_start,
  output logic [IDX_W-1:0]  idx,
  output logic [SLOT_W-1:0] slot,
  output logic [SLOT_W-1:0] next_slot,
  output logic              frame_go,
  output logic              locked,
  output logic              turn_err
);
  logic last_idx;
  logic last_slot;

  always_comb begin
    last_idx  = (idx == IDX_W'(XFERS - 1));
    last_slot = (slot == SLOT_W'(SLOTS - 1));
    frame_go  = xfer_en && (turn_start || (locked && last_idx));
    if (turn_start || last_slot) next_slot = '0;
    else                         next_slot = slot + SLOT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      slot     <= '0;
      locked   <= 1'b0;
      turn_err <= 1'b0;
    end else if (xfer_en) begin
      if (turn_start) begin
        idx      <= '0;
        slot     <= '0;
        locked   <= 1'b1;
        turn_err <= 1'b0;
      end else if (locked) begin
        if (last_idx) begin
          idx  <= '0;
          slot <= next_slot;
          if (last_slot) turn_err <= 1'b1;
        end else begin
          idx <= idx + IDX_W'(1);
        end
      end
    end
  end

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    xfer_en && locked && !turn_start && !last_idx |=> idx == $past(idx) + IDX_W'(1)); // R3
  AST_SLOT_MAX: assert property (@(posedge clk) disable iff (rst)
    slot <= SLOT_W'(SLOTS - 1)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !xfer_en |=> $stable(idx) && $stable(slot) && $stable(turn_err)); // R10
  AST_MARK_RESTART: assert property (@(posedge clk) disable iff (rst)
    xfer_en && turn_start |=> idx == '0 && slot == '0 && !turn_err); // R2
endmodule

// File: rtl/xfr_capture.sv
module xfr_capture #(
  parameter int CODES = 32,
  parameter int CODE_W = 8,
  parameter int SLOT_W = 8,
  localparam int BUF_W = CODES * CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_go,
  input  logic [SLOT_W-1:0] next_slot,
  input  logic [BUF_W-1:0]  codes_in,
  output logic [BUF_W-1:0]  buf_q,
  output logic [CODE_W-1:0] chk_q
);
  logic [CODE_W-1:0] sum;

  always_comb begin
    sum = CODE_W'(next_slot);
    for (int i = 0; i < CODES; i++) sum = sum + codes_in[i*CODE_W +: CODE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      chk_q <= '0;
    end else if (frame_go) begin
      buf_q <= codes_in;
      chk_q <= sum;
    end
  end

  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_go |=> $stable(chk_q) && $stable(buf_q)); // R7
endmodule

// File: rtl/xfr_word.sv
module xfr_word #(
  parameter int XFERS = 8,
  parameter int CODES = 32,
  parameter int CODE_W = 8,
  parameter int SLOT_W = 8,
  parameter int SPARE_W = 3,
  parameter int PARTS = 3,
  parameter int COPIES = 3,
  localparam int IDX_W = $clog2(XFERS),
  localparam int DATA_W = (CODES / XFERS) * CODE_W,
  localparam int WORD_W = DATA_W + 1 + SPARE_W,
  localparam int FIELD_W = PARTS * SPARE_W,
  localparam int BUF_W = CODES * CODE_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     locked,
  input  logic [IDX_W-1:0]         idx,
  input  logic [SLOT_W-1:0]        slot,
  input  logic [BUF_W-1:0]         buf_q,
  input  logic [CODE_W-1:0]        chk_q,
  output logic [COPIES*WORD_W-1:0] link_out,
  output logic                     frame_start
);
  logic [WORD_W-1:0]  word;
  logic [SPARE_W-1:0] spare;
  logic [FIELD_W-1:0] chk_f;
  logic [FIELD_W-1:0] id_f;

  always_comb begin
    chk_f = FIELD_W'(chk_q);
    id_f  = FIELD_W'(slot);
    spare = '0;
    if (int'(idx) < PARTS)
      spare = chk_f[int'(idx)*SPARE_W +: SPARE_W];
    else if (int'(idx) < 2 * PARTS)
      spare = id_f[(int'(idx) - PARTS)*SPARE_W +: SPARE_W];
    if (locked) word = {spare, (idx == '0), buf_q[int'(idx)*DATA_W +: DATA_W]};
    else        word = '0;
  end

  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    always_ff @(posedge clk) begin
      if (rst) link_out[c*WORD_W +: WORD_W] <= '0;
      else     link_out[c*WORD_W +: WORD_W] <= word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) frame_start <= 1'b0;
    else     frame_start <= locked && (idx == '0);
  end

  AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> $past(idx) == '0 && $past(locked)); // R4
  AST_COPY_MATCH: assert property (@(posedge clk) disable iff (rst)
    link_out[WORD_W-1:0] == link_out[COPIES*WORD_W-1 -: WORD_W]); // R8
endmodule

// File: rtl/xfr_framer.sv
module xfr_framer #(
  parameter int CODES = 32,
  parameter int CODE_W = 8,
  parameter int XFERS = 8,
  parameter int SLOTS = 159,
  parameter int SPARE_W = 3,
  parameter int COPIES = 3,
  localparam int IDX_W = $clog2(XFERS),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int PARTS = xfr_pkg::ceil_div(CODE_W, SPARE_W),
  localparam int WORD_W = (CODES / XFERS) * CODE_W + 1 + SPARE_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     xfer_en,
  input  logic                     turn_start,
  input  logic [CODES*CODE_W-1:0]  codes_in,
  output logic [COPIES*WORD_W-1:0] link_out,
  output logic                     frame_start,
  output logic                     turn_err
);
  logic [IDX_W-1:0]        idx;
  logic [SLOT_W-1:0]       slot;
  logic [SLOT_W-1:0]       next_slot;
  logic                    frame_go;
  logic                    locked;
  logic [CODES*CODE_W-1:0] buf_q;
  logic [CODE_W-1:0]       chk_q;

  xfr_slot_ctr #(.XFERS(XFERS), .SLOTS(SLOTS)) u_ctr (
    .clk(clk), .rst(rst), .xfer_en(xfer_en), .turn_start(turn_start),
    .idx(idx), .slot(slot), .next_slot(next_slot), .frame_go(frame_go),
    .locked(locked), .turn_err(turn_err)
  );

  xfr_capture #(.CODES(CODES), .CODE_W(CODE_W), .SLOT_W(SLOT_W)) u_cap (
    .clk(clk), .rst(rst), .frame_go(frame_go), .next_slot(next_slot),
    .codes_in(codes_in), .buf_q(buf_q), .chk_q(chk_q)
  );

  xfr_word #(.XFERS(XFERS), .CODES(CODES), .CODE_W(CODE_W), .SLOT_W(SLOT_W),
             .SPARE_W(SPARE_W), .PARTS(PARTS), .COPIES(COPIES)) u_word (
    .clk(clk), .rst(rst), .locked(locked), .idx(idx), .slot(slot),
    .buf_q(buf_q), .chk_q(chk_q), .link_out(link_out), .frame_start(frame_start)
  );

  AST_ERR_ONLY_WRAP: assert property (@(posedge clk) disable iff (rst)
    $rose(turn_err) |-> $past(slot) == SLOT_W'(SLOTS - 1) && slot == '0); // R9
endmodule

// File: tb/xfr_framer_bench.sv
module xfr_framer_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         xfer_en = 1'b0;
  logic         turn_start = 1'b0;
  logic [255:0] codes_in = '0;
  logic [107:0] link_out;
  logic         frame_start;
  logic         turn_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int  m_idx = 0, m_slot = 0, fnum = 0;
  bit  m_lock = 0, m_err = 0;
  logic [7:0] m_codes [32];

  always #2 clk = ~clk;

  xfr_framer u_xfr_framer (
    .clk(clk), .rst(rst), .xfer_en(xfer_en), .turn_start(turn_start),
    .codes_in(codes_in), .link_out(link_out), .frame_start(frame_start),
    .turn_err(turn_err)
  );

  function automatic logic [255:0] pattern(input int f, input bit junk);
    logic [255:0] v;
    for (int c = 0; c < 32; c++) begin
      if (junk) v[c*8 +: 8] = 8'((c * 71 + 200) ^ f);
      else      v[c*8 +: 8] = 8'(c * 29 + f * 13 + 7);
    end
    return v;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] exp_word();
    logic [35:0] w;
    logic [8:0] chk9, id9;
    int s;
    w = '0;
    if (!m_lock) return w;
    s = m_slot;
    for (int c = 0; c < 32; c++) s = s + m_codes[c];
    chk9 = {1'b0, 8'(s)};
    id9  = {1'b0, 8'(m_slot)};
    for (int j = 0; j < 4; j++) w[j*8 +: 8] = m_codes[4*m_idx + j];
    w[32] = (m_idx == 0);
    if (m_idx < 3)      w[35:33] = chk9[m_idx*3 +: 3];
    else if (m_idx < 6) w[35:33] = id9[(m_idx-3)*3 +: 3];
    return w;
  endfunction

  task automatic check_all();
    logic [35:0] e;
    e = exp_word();
    if (m_idx < 4) check("R3 data", 128'(link_out[31:0]), 128'(e[31:0]));
    else           check("R7 data held", 128'(link_out[31:0]), 128'(e[31:0]));
    check("R4 sync", 128'({link_out[32], frame_start}), 128'({e[32], e[32]}));
    if (m_idx < 3) check("R6 checksum", 128'(link_out[35:33]), 128'(e[35:33]));
    else           check("R5 R6 slot id", 128'(link_out[35:33]), 128'(e[35:33]));
    check("R8 copies", 128'({link_out[107:72], link_out[71:36]}), 128'({link_out[35:0], link_out[35:0]}));
    check("R9 err", 128'(turn_err), 128'(m_err));
  endtask

  task automatic step(input bit ts);
    bit fr;
    fr = ts || (m_lock && m_idx == 7);
    @(negedge clk);
    xfer_en = 1'b1;
    turn_start = ts;
    codes_in = pattern(fnum, !fr);
    if (ts) begin
      m_idx = 0; m_slot = 0; m_err = 0; m_lock = 1;
    end else if (m_lock) begin
      if (m_idx == 7) begin
        m_idx = 0;
        if (m_slot == 158) begin m_slot = 0; m_err = 1; end
        else m_slot++;
      end else m_idx++;
    end
    if (fr) begin
      for (int c = 0; c < 32; c++) m_codes[c] = codes_in[c*8 +: 8];
      fnum++;
    end
    @(negedge clk);
    xfer_en = 1'b0;
    turn_start = 1'b0;
    codes_in = pattern(fnum + 3, 1'b1);
    @(negedge clk);
    check_all();
  endtask

  task automatic idle_check();
    logic [109:0] snap;
    snap = {link_out, frame_start, turn_err};
    repeat (3) @(negedge clk);
    check("R10 idle hold", 128'({link_out, frame_start, turn_err}), 128'(snap));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset", 128'({link_out, frame_start, turn_err}), 128'(0));
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step(1'b0);
      check("R1 unlocked zero", 128'({link_out, frame_start}), 128'(0));
    end
    step(1'b1);
    check("R2 marker start", 128'({frame_start, link_out[35:33]}), 128'({1'b1, exp_word()[35:33]}));
    for (int t = 1; t < 159 * 8; t++) begin
      step(1'b0);
      if (t % 97 == 0) idle_check();
    end
    step(1'b1);
    check("R5 turn wraps", 128'(m_slot), 128'(0));
    for (int t = 1; t < 159 * 8 + 16; t++) begin
      step(1'b0);
      if (t == 159 * 8) check("R9 err raised", 128'(turn_err), 128'(1));
      if (t % 131 == 0) idle_check();
    end
    step(1'b0); step(1'b0); step(1'b0);
    step(1'b1);
    check("R2 mid-frame restart", 128'({turn_err, frame_start}), 128'({1'b0, 1'b1}));
    for (int t = 0; t < 40; t++) step(1'b0);
    idle_check();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule